// File: doc/BRIEF.md
# Backplane Slave Window Decoder

This block sits on the slave side of a backplane bridge. Each incoming backplane address comes with an address space class (32, 24 or 16 address bits) and a strobe. The block compares the address against four programmable general-purpose windows and one fixed window that points at the bridge's own control registers. A hit in a general window gives the winning window index and a local bus address. That address is built by adding the window's offset to the page part of the address. A hit in the register window is flagged on its own output.

Software loads each window through a small write port: an enable, a space class, a start page, an end page and an offset page, all in 64 KB units. The decoder looks only at address bits 31:16 when it compares. The result appears on the outputs one clock after the strobe. The block moves no data and has no notion of bus protocol timing.

Top module: `slave_window_decoder`

## Requirements
- R1: After synchronous reset all outputs are zero and every window is disabled, so no strobed address yields `hit` until a window is enabled.
- R2: A window hits when it is enabled, its space equals `bk_space`, and start <= page < end, where page is the masked `bk_addr[31:16]`. Start is inclusive and end is exclusive. On a strobed miss, `hit`, `reg_hit`, `win_idx` and `local_addr` become zero.
- R3: A disabled window never hits. A window whose space differs from `bk_space` never hits. Space code 3 (reserved) never hits any window.
- R4: Space codes are 0 = A16, 1 = A24 and 2 = A32. Before comparison, A24 forces address bits 31:24 to zero and A16 forces bits 31:16 to zero.
- R5: When several windows hit, `win_idx` reports the lowest-numbered one, and the translation uses that window's offset.
- R6: The register window covers one 64 KB page, given by `REG_PAGE`, in space `REG_SPACE` (defaults: A24, page 0x00FF). A match there takes precedence over every general window: `reg_hit`=1, `hit`=0, `win_idx`=0, `local_addr`={16'h0, bk_addr[15:0]}.
- R7: On a general hit, `local_addr[31:16]` = (masked page + offset) mod 2^16. `local_addr[15:0]` equals `bk_addr[15:0]`.
- R8: The outputs are registered. A strobe at one rising edge shows its result after that edge. An edge with `bk_strobe` low drives `hit` and `reg_hit` to 0 and leaves `win_idx` and `local_addr` unchanged.
- R9: A config write (`cfg_we`=1) updates window `cfg_win` at the clock edge. The field is chosen by `cfg_fld`: 0 = control, with data[0] as enable and data[2:1] as space; 1 = start page; 2 = end page; 3 = offset page. Pages are taken from data[31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_win | input | 2 | Window selected for the write |
| cfg_fld | input | 2 | Field selected for the write |
| cfg_data | input | 32 | Write data |
| bk_strobe | input | 1 | Address strobe from the backplane |
| bk_addr | input | 32 | Backplane address |
| bk_space | input | 2 | Address space class |
| hit | output | 1 | General window hit |
| win_idx | output | 2 | Index of the winning window |
| local_addr | output | 32 | Translated local address |
| reg_hit | output | 1 | Register window hit |

## Verification
The hardest case to reach is an address that several decoders claim at once. Two general windows have to overlap in both page range and space, and the register page has to fall inside an enabled general window. Only then do the lowest-index rule and the register precedence actually choose between live matches. The bench programs two overlapping A32 windows, probes the shared band and both edges of each window, and later widens an A24 window across the register page. The offsets are chosen so that one translation wraps past 2^16 pages.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 16;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int SPACE_W  = 2;

    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [SPACE_W-1:0] {
        SP_A16 = 2'd0,
        SP_A24 = 2'd1,
        SP_A32 = 2'd2,
        SP_RSV = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        FLD_CTRL   = 2'd0,
        FLD_START  = 2'd1,
        FLD_END    = 2'd2,
        FLD_OFFSET = 2'd3
    } field_e;

    typedef struct packed {
        logic   en;
        space_e space;
        page_t  start;
        page_t  stop;
        page_t  offset;
    } win_cfg_t;

    // Zero the page bits that the given space class does not carry.
    function automatic page_t mask_page(input page_t pg, input space_e sp);
        page_t r;
        case (sp)
            SP_A32:  r = pg;
            SP_A24:  r = {{(PAGE_W-8){1'b0}}, pg[7:0]};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/swd_cfg_regs.sv
module swd_cfg_regs
    import swd_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   win,
    input  field_e             fld,
    input  logic [ADDR_W-1:0]  data,
    output win_cfg_t           cfg [NUM_WIN]
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '{en: 1'b0, space: SP_A16, start: '0, stop: '0, offset: '0};
            end else if (we && win == IDX_W'(g)) begin
                case (fld)
                    FLD_CTRL: begin
                        cfg[g].en    <= data[0];
                        cfg[g].space <= space_e'(data[2:1]);
                    end
                    FLD_START:  cfg[g].start  <= data[ADDR_W-1:PAGE_LSB];
                    FLD_END:    cfg[g].stop   <= data[ADDR_W-1:PAGE_LSB];
                    default:    cfg[g].offset <= data[ADDR_W-1:PAGE_LSB];
                endcase
            end
        end
    end

endmodule

// File: rtl/swd_window_match.sv
module swd_window_match
    import swd_pkg::*;
(
    input  win_cfg_t cfg,
    input  page_t    page,
    input  space_e   space,
    output logic     match,
    output page_t    xlat
);

    always_comb begin
        match = cfg.en && (space != SP_RSV) && (cfg.space == space)
                && (page >= cfg.start) && (page < cfg.stop);
        xlat  = page + cfg.offset;
    end

endmodule

// File: rtl/swd_prio_pick.sv
module swd_prio_pick #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/slave_window_decoder.sv
module slave_window_decoder
    import swd_pkg::*;
#(
    parameter int          NUM_WIN   = 4,
    parameter logic [1:0]  REG_SPACE = 2'd1,
    parameter logic [15:0] REG_PAGE  = 16'h00FF,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_win,
    input  logic [1:0]         cfg_fld,
    input  logic [ADDR_W-1:0]  cfg_data,
    input  logic               bk_strobe,
    input  logic [ADDR_W-1:0]  bk_addr,
    input  logic [1:0]         bk_space,
    output logic               hit,
    output logic [IDX_W-1:0]   win_idx,
    output logic [ADDR_W-1:0]  local_addr,
    output logic               reg_hit
);

    win_cfg_t           cfg [NUM_WIN];
    space_e             sp;
    page_t              page;
    logic [NUM_WIN-1:0] match;
    page_t              xlat [NUM_WIN];
    logic               any;
    logic [IDX_W-1:0]   pick;
    logic               reg_sel;

    swd_cfg_regs #(.NUM_WIN(NUM_WIN)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .win  (cfg_win),
        .fld  (field_e'(cfg_fld)),
        .data (cfg_data),
        .cfg  (cfg)
    );

    assign sp   = space_e'(bk_space);
    assign page = mask_page(bk_addr[ADDR_W-1:PAGE_LSB], sp);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        swd_window_match u_match (
            .cfg   (cfg[g]),
            .page  (page),
            .space (sp),
            .match (match[g]),
            .xlat  (xlat[g])
        );
    end

    swd_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .req (match),
        .any (any),
        .idx (pick)
    );

    assign reg_sel = (sp == space_e'(REG_SPACE)) && (sp != SP_RSV) && (page == REG_PAGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit        <= 1'b0;
            reg_hit    <= 1'b0;
            win_idx    <= '0;
            local_addr <= '0;
        end else begin
            hit     <= bk_strobe && any && !reg_sel;
            reg_hit <= bk_strobe && reg_sel;
            if (bk_strobe) begin
                if (reg_sel) begin
                    win_idx    <= '0;
                    local_addr <= {{PAGE_W{1'b0}}, bk_addr[PAGE_LSB-1:0]};
                end else if (any) begin
                    win_idx    <= pick;
                    local_addr <= {xlat[pick], bk_addr[PAGE_LSB-1:0]};
                end else begin
                    win_idx    <= '0;
                    local_addr <= '0;
                end
            end
        end
    end

    // R6: a general hit and a register hit are never flagged together
    p_excl_r6: assert property (@(posedge clk) disable iff (rst) !(hit && reg_hit));

    // R8: no strobe at the previous edge means no hit now
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bk_strobe) |-> (!hit && !reg_hit));

    // R8: without a strobe the reported index and address are held
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bk_strobe) |-> ($stable(local_addr) && $stable(win_idx)));

    // R7: the in-page offset bits pass through on a general hit
    p_low_pass_r7: assert property (@(posedge clk) disable iff (rst)
        hit |-> (local_addr[PAGE_LSB-1:0] == $past(bk_addr[PAGE_LSB-1:0])));

    // R6: a register hit carries only the in-page offset
    p_reg_local_r6: assert property (@(posedge clk) disable iff (rst)
        reg_hit |-> (local_addr[ADDR_W-1:PAGE_LSB] == '0 && win_idx == '0));

endmodule

// File: tb/tb_slave_window_decoder.sv
module tb_slave_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_win;
    logic [1:0]  cfg_fld;
    logic [31:0] cfg_data;
    logic        bk_strobe;
    logic [31:0] bk_addr;
    logic [1:0]  bk_space;
    logic        hit;
    logic [1:0]  win_idx;
    logic [31:0] local_addr;
    logic        reg_hit;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_window_decoder dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_fld(cfg_fld), .cfg_data(cfg_data),
        .bk_strobe(bk_strobe), .bk_addr(bk_addr), .bk_space(bk_space),
        .hit(hit), .win_idx(win_idx), .local_addr(local_addr), .reg_hit(reg_hit)
    );

    // {addr, space, hit, reg_hit, idx, local}
    localparam logic [69:0] VEC [NV] = '{
        {32'h1234_5678, 2'd2, 1'b1, 1'b0, 2'd0, 32'h5234_5678}, // R2 R7
        {32'h1000_0000, 2'd2, 1'b1, 1'b0, 2'd0, 32'h5000_0000}, // R2 start inclusive
        {32'h0FFF_FFFF, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0000_0000}, // R2 below start
        {32'h1800_0004, 2'd2, 1'b1, 1'b0, 2'd0, 32'h5800_0004}, // R5 overlap
        {32'h2000_0010, 2'd2, 1'b1, 1'b0, 2'd1, 32'h1000_0010}, // R7 wrap, R2 end exclusive
        {32'h2FFF_FFFF, 2'd2, 1'b1, 1'b0, 2'd1, 32'h1FFF_FFFF}, // R7
        {32'h3000_0000, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0000_0000}, // R2 end
        {32'hAB15_4321, 2'd1, 1'b1, 1'b0, 2'd2, 32'h8015_4321}, // R4 A24
        {32'h0015_4321, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0000_0000}, // R3 space mismatch
        {32'hFFFF_1234, 2'd0, 1'b1, 1'b0, 2'd3, 32'h7777_1234}, // R4 A16
        {32'h00FF_0042, 2'd1, 1'b0, 1'b1, 2'd0, 32'h0000_0042}, // R6
        {32'h1234_5678, 2'd3, 1'b0, 1'b0, 2'd0, 32'h0000_0000}, // R3 reserved
        {32'hAB20_0000, 2'd1, 1'b0, 1'b0, 2'd0, 32'h0000_0000}  // R2 A24 end
    };

    task automatic wr(input logic [1:0] w, input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = w; cfg_fld = f; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [1:0] w, input logic [1:0] sp,
                         input logic [15:0] s, input logic [15:0] e, input logic [15:0] o);
        wr(w, 2'd1, {s, 16'h0});
        wr(w, 2'd2, {e, 16'h0});
        wr(w, 2'd3, {o, 16'h0});
        wr(w, 2'd0, {29'h0, sp, 1'b1});
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] sp, input string req,
                         input logic eh, input logic er, input logic [1:0] ei,
                         input logic [31:0] el);
        @(negedge clk);
        bk_addr = a; bk_space = sp; bk_strobe = 1'b1;
        @(negedge clk);
        bk_strobe = 1'b0;
        checks++;
        if (hit !== eh || reg_hit !== er || win_idx !== ei || local_addr !== el) begin
            errors++;
            $display("FAIL %s addr=%h: got hit=%b reg=%b idx=%0d local=%h exp hit=%b reg=%b idx=%0d local=%h",
                     req, a, hit, reg_hit, win_idx, local_addr, eh, er, ei, el);
        end
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_win = '0; cfg_fld = '0; cfg_data = '0;
        bk_strobe = 1'b0; bk_addr = '0; bk_space = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of the outputs
        checks++;
        if (hit !== 1'b0 || reg_hit !== 1'b0 || win_idx !== 2'd0 || local_addr !== 32'h0) begin
            errors++;
            $display("FAIL R1 reset: got hit=%b reg=%b idx=%0d local=%h exp all zero",
                     hit, reg_hit, win_idx, local_addr);
        end
        // R1: windows disabled after reset
        probe(32'h0000_1234, 2'd0, "R1", 1'b0, 1'b0, 2'd0, 32'h0);
        probe(32'h1234_5678, 2'd2, "R1", 1'b0, 1'b0, 2'd0, 32'h0);

        // R9: program the windows through the write port
        setup(2'd0, 2'd2, 16'h1000, 16'h2000, 16'h4000);
        setup(2'd1, 2'd2, 16'h1800, 16'h3000, 16'hF000);
        setup(2'd2, 2'd1, 16'h0010, 16'h0020, 16'h8000);
        setup(2'd3, 2'd0, 16'h0000, 16'h0001, 16'h7777);

        for (int i = 0; i < NV; i++) begin
            probe(VEC[i][69:38], VEC[i][37:36], "R2/R3/R4/R5/R6/R7 vector",
                  VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:0]);
        end

        // R8: an edge without a strobe clears the flags and holds the address
        probe(32'h1234_5678, 2'd2, "R8", 1'b1, 1'b0, 2'd0, 32'h5234_5678);
        @(negedge clk);
        bk_addr = 32'h2000_0010;
        @(negedge clk);
        checks++;
        if (hit !== 1'b0 || reg_hit !== 1'b0 || win_idx !== 2'd0 || local_addr !== 32'h5234_5678) begin
            errors++;
            $display("FAIL R8 hold: got hit=%b reg=%b idx=%0d local=%h exp hit=0 reg=0 idx=0 local=52345678",
                     hit, reg_hit, win_idx, local_addr);
        end

        // R6: the register page wins over a general window that covers it
        wr(2'd2, 2'd2, 32'h0100_0000);
        probe(32'h00FF_0042, 2'd1, "R6", 1'b0, 1'b1, 2'd0, 32'h0000_0042);
        probe(32'h00FE_0001, 2'd1, "R9", 1'b1, 1'b0, 2'd2, 32'h80FE_0001);

        // R3: a disabled window no longer hits
        wr(2'd3, 2'd0, 32'h0000_0000);
        probe(32'hFFFF_1234, 2'd0, "R3", 1'b0, 1'b0, 2'd0, 32'h0);

        // R5: with window 0 disabled, window 1 owns the overlap band
        wr(2'd0, 2'd0, 32'h0000_0004);
        probe(32'h1800_0004, 2'd2, "R5", 1'b1, 1'b0, 2'd1, 32'h0800_0004);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule